// File: doc/BRIEF.md
# Multi-Channel Double-Buffered DAC Code Register Bank

This block holds the digital codes for a group of 12-bit digital-to-analog converter channels behind a 16-bit parallel write bus. Every channel has two stages. The first stage is a staging register that the host fills. The second stage is an output register that drives the converter code. An address decoder gives each channel its own write address and adds one extra address that acts as a shared load strobe.

In normal use the host writes one word to each channel's staging register, one channel after another. None of the outputs moves during these writes. The host then writes once to the load address. On that single edge every staging register is copied into its output register, so all channels change together. An external load input does the same job as the load address. It lets several banks, or an outside timing source, start one common update.

Each channel can also be set to transparent mode. In this mode a write to the channel's address goes straight to its output register, and no load is needed.

Top module: `dac_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every staging register and every output code reads zero. Asserting `rst_n` low clears the outputs at once, without waiting for a clock edge.
- R2: In buffered mode (`transparent_i[i]`=0), a write to channel i's address stores the word in the staging register and leaves every output code unchanged.
- R3: A write to the load address (address 3 with the default `NUM_CH`=3) copies every channel's staging register into its output register on the same clock edge. The new codes appear after that edge.
- R4: Only bits 11:0 of `wdata_i` form the code. Bits 15:12 have no effect on any channel.
- R5: A write to an address that is neither a channel address (0 to `NUM_CH`-1) nor the load address changes no staging register and no output.
- R6: In transparent mode (`transparent_i[i]`=1), a write to channel i's address updates its output code on that same edge. If a load happens in the same cycle, the written word takes precedence for that channel.
- R7: A cycle with `ext_load_i`=1 has the same effect as a write to the load address.
- R8: If a buffered channel's staging register is written in the same cycle as a load, the load transfers the old staging value. The new word reaches the output only at the next load.
- R9: When a cycle has no load and no transparent write, every output code holds its value. Codes cover the full range 0x000 to 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously. |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W (4) | Write address. Channel i is at address i, and the load strobe is at address `NUM_CH`. |
| wdata_i | input | BUS_W (16) | Write data. Only the low 12 bits are used. |
| ext_load_i | input | 1 | External load strobe that updates all channels |
| transparent_i | input | NUM_CH (3) | Per-channel transparent-mode select |
| dac_code_o | output | NUM_CH*CODE_W (36) | Output codes. Channel i sits at bits [12i+11:12i]. |

## Verification
The assertions assume that the address, data, strobe and mode inputs are stable and known at each rising clock edge. They also assume that `transparent_i` is treated as a static setting around the writes it governs. The stimulus changes every input only on the falling edge and changes the mode bits only in cycles without a write. The properties compare output codes against the staging values from the previous cycle. This relies on reset being released through the internal synchronizer before any write. The stimulus therefore waits several cycles after every reset release before it issues its first bus operation.

// File: rtl/dacbank_pkg.sv
`timescale 1ns/1ps
package dacbank_pkg;
  // Source that feeds an output register on the next edge
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_STAGE = 2'd1,
    SRC_BUS   = 2'd2
  } dac_src_e;

  localparam int DEF_NUM_CH = 3;
  localparam int DEF_CODE_W = 12;
  localparam int DEF_BUS_W  = 16;
  localparam int DEF_ADDR_W = 4;
endpackage

// File: rtl/dac_rst_sync.sv
`timescale 1ns/1ps
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dac_addr_decode.sv
`timescale 1ns/1ps
module dac_addr_decode #(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 4,
  parameter int LOAD_ADDR = NUM_CH
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_load,
  output logic [NUM_CH-1:0] ch_sel,
  output logic              load
);
  localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(LOAD_ADDR);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(g);
    always_comb begin
      ch_sel[g] = wr_en && (addr == CH_A);
    end
  end

  always_comb begin
    load = (wr_en && (addr == LOAD_A)) || ext_load;
  end
endmodule

// File: rtl/dac_channel.sv
`timescale 1ns/1ps
module dac_channel
  import dacbank_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              load,
  input  logic              transparent,
  input  logic [CODE_W-1:0] wcode,
  output logic [CODE_W-1:0] stage_code,
  output logic [CODE_W-1:0] dac_code
);
  logic [CODE_W-1:0] stage_q, stage_d;
  logic [CODE_W-1:0] out_q, out_d;
  logic              stage_en, out_en;
  dac_src_e          out_src;

  // Source selection for the output register
  always_comb begin
    if (transparent && sel) begin
      out_src = SRC_BUS;
    end else if (load) begin
      out_src = SRC_STAGE;
    end else begin
      out_src = SRC_HOLD;
    end
  end

  // Next-state logic
  always_comb begin
    stage_en = sel;
    stage_d  = wcode;
    out_en   = (out_src != SRC_HOLD);
    case (out_src)
      SRC_BUS:   out_d = wcode;
      SRC_STAGE: out_d = stage_q;
      default:   out_d = out_q;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  assign stage_code = stage_q;
  assign dac_code   = out_q;
endmodule

// File: rtl/dac_bank.sv
`timescale 1ns/1ps
module dac_bank
  import dacbank_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int CODE_W = DEF_CODE_W,
  parameter int BUS_W  = DEF_BUS_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BUS_W-1:0]         wdata_i,
  input  logic                     ext_load_i,
  input  logic [NUM_CH-1:0]        transparent_i,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o
);
  localparam int LOAD_ADDR = NUM_CH;
  localparam int TOT_W     = NUM_CH * CODE_W;

  logic              rst_n_sync;
  logic [NUM_CH-1:0] ch_sel;
  logic              load;
  logic [CODE_W-1:0] wcode;
  logic [TOT_W-1:0]  stage_flat;
  logic              unused_hi;

  assign wcode     = wdata_i[CODE_W-1:0];
  assign unused_hi = ^wdata_i[BUS_W-1:CODE_W];

  dac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dac_addr_decode #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .LOAD_ADDR (LOAD_ADDR)
  ) u_dec (
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .ext_load (ext_load_i),
    .ch_sel   (ch_sel),
    .load     (load)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n_sync),
      .sel         (ch_sel[g]),
      .load        (load),
      .transparent (transparent_i[g]),
      .wcode       (wcode),
      .stage_code  (stage_flat[g*CODE_W +: CODE_W]),
      .dac_code    (dac_code_o[g*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_bank_chk.sv
`timescale 1ns/1ps
module dac_bank_chk #(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 12,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst_n_s,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [BUS_W-1:0]         wdata,
  input logic                     ext_load,
  input logic [NUM_CH-1:0]        transparent,
  input logic [NUM_CH*CODE_W-1:0] stage_codes,
  input logic [NUM_CH*CODE_W-1:0] dac_codes
);
  localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(NUM_CH);

  logic any_load;
  assign any_load = (wr_en && addr == LOAD_A) || ext_load;

  // R1: outputs cleared while the synchronized reset is low
  always @(posedge clk) begin
    if (!rst_n_s) begin
      a_reset_zero_r1: assert (dac_codes == '0 && stage_codes == '0)
        else $error("R1 outputs not zero in reset");
    end
  end

  // R5: unmapped or absent writes leave staging registers alone
  p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_en || addr >= ADDR_W'(NUM_CH)) |=> $stable(stage_codes));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(g);

    // R2/R4: channel write captures only the low code bits
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
      (wr_en && addr == CH_A) |=>
        stage_codes[g*CODE_W +: CODE_W] == $past(wdata[CODE_W-1:0]));

    // R3/R7/R8: load copies the previous staging value
    p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
      (any_load && !(transparent[g] && wr_en && addr == CH_A)) |=>
        dac_codes[g*CODE_W +: CODE_W] == $past(stage_codes[g*CODE_W +: CODE_W]));

    // R6: transparent write reaches the output directly
    p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
      (transparent[g] && wr_en && addr == CH_A) |=>
        dac_codes[g*CODE_W +: CODE_W] == $past(wdata[CODE_W-1:0]));

    // R9: output holds without a load or transparent write
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
      (!any_load && !(transparent[g] && wr_en && addr == CH_A)) |=>
        $stable(dac_codes[g*CODE_W +: CODE_W]));
  end
endmodule

bind dac_bank dac_bank_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .BUS_W  (BUS_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_sync),
  .wr_en       (wr_en_i),
  .addr        (addr_i),
  .wdata       (wdata_i),
  .ext_load    (ext_load_i),
  .transparent (transparent_i),
  .stage_codes (stage_flat),
  .dac_codes   (dac_code_o)
);

// File: tb/dac_bank_tb.sv
`timescale 1ns/1ps
module dac_bank_tb;
  localparam int NCH = 3;
  localparam int CW  = 12;

  logic            clk;
  logic            rst_n;
  logic            wr_en;
  logic [3:0]      addr;
  logic [15:0]     wdata;
  logic            ext_load;
  logic [NCH-1:0]  transp;
  logic [NCH*CW-1:0] dac_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [CW-1:0] m_stage [NCH];
  logic [CW-1:0] m_dac   [NCH];

  logic [NCH*CW-1:0] q_exp [$];
  string             q_tag [$];

  dac_bank u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .ext_load_i    (ext_load),
    .transparent_i (transp),
    .dac_code_o    (dac_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [NCH*CW-1:0] pack_model();
    logic [NCH*CW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CW +: CW] = m_dac[i];
    return v;
  endfunction

  // Monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [NCH*CW-1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (dac_code !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, dac_code, e);
      end
    end
  end

  // Driver: one bus cycle, model update, expected item pushed
  task automatic bus_op(input logic w, input logic [3:0] a, input logic [15:0] d,
                        input logic el, input string tag);
    logic ld;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ext_load = el;
    @(posedge clk);
    #1;
    ld = (w && a == 4'(NCH)) || el;
    for (int i = 0; i < NCH; i++) begin
      if (w && a == 4'(i) && transp[i]) m_dac[i] = d[CW-1:0];
      else if (ld) m_dac[i] = m_stage[i];
    end
    for (int i = 0; i < NCH; i++)
      if (w && a == 4'(i)) m_stage[i] = d[CW-1:0];
    q_exp.push_back(pack_model());
    q_tag.push_back(tag);
    wr_en = 1'b0; ext_load = 1'b0;
  endtask

  task automatic clear_model();
    for (int i = 0; i < NCH; i++) begin m_stage[i] = '0; m_dac[i] = '0; end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; ext_load = 1'b0; transp = '0;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    bus_op(1'b0, 4'd0, 16'h0000, 1'b0, "R1 reset value");
    // R2: staged writes leave outputs at zero
    bus_op(1'b1, 4'd0, 16'h0123, 1'b0, "R2 stage ch0");
    bus_op(1'b1, 4'd1, 16'h0456, 1'b0, "R2 stage ch1");
    bus_op(1'b1, 4'd2, 16'h0789, 1'b0, "R2 stage ch2");
    bus_op(1'b0, 4'd0, 16'h0000, 1'b0, "R9 hold before load");
    // R3: one load write updates all channels
    bus_op(1'b1, 4'd3, 16'h0000, 1'b0, "R3 global load");
    // R4 / R9: upper bits ignored, full-scale codes
    bus_op(1'b1, 4'd0, 16'hFABC, 1'b0, "R4 stage with high bits");
    bus_op(1'b1, 4'd1, 16'h0FFF, 1'b0, "R9 stage full scale");
    bus_op(1'b1, 4'd2, 16'hF000, 1'b0, "R4 stage zero code");
    bus_op(1'b1, 4'd3, 16'hFFFF, 1'b0, "R4 R9 load range");
    // R5: unmapped addresses
    bus_op(1'b1, 4'd9, 16'h0555, 1'b0, "R5 unmapped write");
    bus_op(1'b1, 4'd15, 16'h0AAA, 1'b0, "R5 unmapped write high");
    bus_op(1'b1, 4'd3, 16'h0000, 1'b0, "R5 load after unmapped");
    // R6: transparent channel 1
    @(negedge clk) transp = 3'b010;
    bus_op(1'b1, 4'd1, 16'h0321, 1'b0, "R6 transparent write");
    // R7: external load
    bus_op(1'b1, 4'd0, 16'h0111, 1'b0, "R2 stage ch0 again");
    bus_op(1'b0, 4'd0, 16'h0000, 1'b1, "R7 external load");
    // R8: write and load in the same cycle
    bus_op(1'b1, 4'd2, 16'h0222, 1'b1, "R8 write with load");
    bus_op(1'b0, 4'd0, 16'h0000, 1'b1, "R8 next load");
    // R6: transparent write wins over a simultaneous load
    bus_op(1'b1, 4'd0, 16'h0777, 1'b0, "R2 stage ch0 third");
    bus_op(1'b1, 4'd1, 16'h0BCD, 1'b1, "R6 transparent with load");
    @(negedge clk) transp = 3'b000;
    bus_op(1'b0, 4'd0, 16'h0000, 1'b0, "R9 idle hold");

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (dac_code !== '0) begin
      errors++;
      $display("FAIL R1 async clear: actual %h expected %h", dac_code, {NCH*CW{1'b0}});
    end
    clear_model();
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    bus_op(1'b1, 4'd3, 16'h0000, 1'b0, "R1 staging cleared by reset");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule